// File: doc/BRIEF.md
# NAND Access Width Adapter

This block converts single host accesses into sequences of device cycles on a narrow NAND I/O port. The host side carries up to 32 bits per access and names one of three windows: a command window, an address window and a data window. The device side moves 8 or 16 bits per cycle. Each host write is split into device words starting from the least significant part. Each host read gathers device words into the host word, again least significant part first. The device kind and width come from plain configuration pins that the chip-select logic supplies.

The host request and the host response are valid/ready channels. A request is taken only when `host_req_valid` and `host_req_ready` are both high on a rising edge. `host_req_ready` is high only while no access is in progress and no response is pending. A read response stays on `host_rsp_valid`/`host_rsp_rdata`, unchanged, until `host_rsp_ready` is seen high. Each device cycle is a valid/ready handshake. `nand_valid` and every device-side output stay stable until `nand_ready` completes the cycle, and `nand_rdata` is sampled on that edge. Timing generation, chip-select decoding and error correction are left to other blocks.

Top module: `nand_width_adapter`

## Requirements
- R1: Window code 01 (command) drives `nand_cle` high, code 10 (address) drives `nand_ale` high, and codes 00 and 11 (data) drive neither, on every device cycle of that access. `nand_cle` and `nand_ale` are never high together.
- R2: When `cs_dev_size[0]` is 0 (8-bit device), a write takes 1, 2 or 4 device cycles for size codes 00, 01 and 10. Host byte i goes out in cycle i on `nand_wdata[7:0]`, and `nand_wdata[15:8]` is zero.
- R3: With an 8-bit device, a read takes one cycle per host byte. The byte from cycle i, taken from `nand_rdata[7:0]`, lands at bits 8i+7..8i of the response.
- R4: When `cs_dev_size[0]` is 1 (16-bit device), size code 01 takes one cycle and size code 10 takes two. The low halfword goes first, in both directions.
- R5: A byte access (size code 00) to a 16-bit device is one 16-bit cycle. A write drives `host_req_wdata[15:0]`. A read returns `nand_rdata[7:0]` zero-extended.
- R6: The device width depends only on `cs_dev_size[0]`. `cs_dev_size[1]` has no effect.
- R7: Device cycles happen only when `cs_dev_type` is 2'b10 at acceptance. Otherwise a write is dropped with no device cycle, and a read returns zero with no device cycle.
- R8: `busy` rises in the cycle after an accepted access that needs device cycles. It falls right after the handshake of the final device cycle. `host_req_ready` is high only when idle with no response pending.
- R9: Read response bits above the access size are zero.
- R10: A read of the command or address window makes no device cycle and returns zero. Device read cycles never raise `nand_cle` or `nand_ale`.
- R11: Size code 11 behaves as a 32-bit access. `nand_valid` and `nand_wdata` hold until `nand_ready`, and a response holds until `host_rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted when high |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_window | input | 2 | 00/11 data, 01 command, 10 address |
| host_req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Read response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read response data |
| cs_dev_type | input | 2 | Device kind; 2'b10 = NAND |
| cs_dev_size | input | 2 | Bit 0: 0 = 8-bit, 1 = 16-bit device |
| busy | output | 1 | Device cycles in progress |
| nand_valid | output | 1 | Device cycle request |
| nand_ready | input | 1 | Device completes the cycle |
| nand_write | output | 1 | Device cycle direction, 1 = write |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_wdata | output | 16 | Device write word |
| nand_rdata | input | 16 | Device read word |

## Verification
The bench builds the block with its default widths: a 32-bit host word and a 16-bit widest device word. With these values, switching `cs_dev_size` at run time covers every cycle count (one, two and four) in both directions and every lane position, including the mismatched byte-on-16-bit case. A stalling device model holds `nand_ready` low so that the hold of device outputs and `busy` can be observed. Non-NAND device kinds and reads of the control windows cover the zero-cycle paths.

// File: rtl/nand_adapt_pkg.sv
package nand_adapt_pkg;

  typedef enum logic [1:0] {
    WIN_DATA  = 2'b00,
    WIN_CMD   = 2'b01,
    WIN_ADDR  = 2'b10,
    WIN_DATA2 = 2'b11
  } win_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_DEV  = 2'b01,
    S_RESP = 2'b10
  } state_e;

  localparam logic [1:0] DEVTYPE_NAND = 2'b10;

  typedef struct packed {
    logic write;
    logic cle;
    logic ale;
    logic wide;
  } acc_kind_t;

endpackage

// File: rtl/nand_adapt_plan.sv
module nand_adapt_plan
  import nand_adapt_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int DEV_BYTES  = 2,
  parameter int CNT_W      = $clog2(HOST_BYTES) + 1
) (
  input  logic [1:0]            win,
  input  logic                  write,
  input  logic [1:0]            size,
  input  logic [1:0]            dev_type,
  input  logic [1:0]            dev_size,
  output acc_kind_t             kind,
  output logic [CNT_W-1:0]      ncycles,
  output logic [HOST_BYTES-1:0] mask
);

  localparam int LOG_HB = $clog2(HOST_BYTES);
  localparam int LOG_DB = $clog2(DEV_BYTES);

  logic is_data, active, wide;
  int   size_log, nbytes, n;

  always_comb begin
    is_data  = (win == WIN_DATA) || (win == WIN_DATA2);
    active   = (dev_type == DEVTYPE_NAND) && (write || is_data);
    // only the low bit of the width field counts
    wide     = dev_size[0];
    size_log = (int'(size) > LOG_HB) ? LOG_HB : int'(size);
    nbytes   = 1 << size_log;
    if (wide) n = (nbytes > DEV_BYTES) ? (nbytes >> LOG_DB) : 1;
    else      n = nbytes;
    ncycles  = active ? CNT_W'(n) : '0;
    for (int b = 0; b < HOST_BYTES; b++) mask[b] = (b < nbytes);
    kind.write = write;
    kind.cle   = (win == WIN_CMD);
    kind.ale   = (win == WIN_ADDR);
    kind.wide  = wide;
  end

endmodule

// File: rtl/nand_adapt_seq.sv
module nand_adapt_seq
  import nand_adapt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] req_ncycles,
  output logic             req_ready,
  output logic             load,
  output logic             busy,
  output logic             dev_valid,
  input  logic             dev_ready,
  output logic             step,
  output logic [CNT_W-1:0] idx,
  output logic             rsp_valid,
  input  logic             rsp_ready
);

  state_e           state;
  logic [CNT_W-1:0] idx_q, last_q;
  logic             write_q;

  assign req_ready = (state == S_IDLE);
  assign load      = req_valid && req_ready;
  assign busy      = (state == S_DEV);
  assign dev_valid = busy;
  assign step      = dev_valid && dev_ready;
  assign rsp_valid = (state == S_RESP);
  assign idx       = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      write_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (load) begin
          idx_q   <= '0;
          last_q  <= req_ncycles - CNT_W'(1);
          write_q <= req_write;
          if (req_ncycles != '0) state <= S_DEV;
          else if (!req_write)   state <= S_RESP;
        end
        S_DEV: if (dev_ready) begin
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == last_q) state <= write_q ? S_IDLE : S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));

  // R11
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid);

  // R8
  write_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && (idx_q == last_q) && write_q |=> req_ready && !busy);

endmodule

// File: rtl/nand_adapt_datapath.sv
module nand_adapt_datapath
  import nand_adapt_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int DEV_BYTES  = 2,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  acc_kind_t               kind_in,
  input  logic [HOST_BYTES-1:0]   mask_in,
  input  logic [HOST_BYTES*8-1:0] wdata_in,
  input  logic [CNT_W-1:0]        idx,
  input  logic [DEV_BYTES*8-1:0]  dev_rdata,
  output logic [DEV_BYTES*8-1:0]  dev_wdata,
  output acc_kind_t               kind_q,
  output logic [HOST_BYTES*8-1:0] rdata
);

  localparam int LOG_DB = $clog2(DEV_BYTES);
  localparam int HW     = HOST_BYTES * 8;

  logic [HW-1:0]         wdata_q, acc_q, acc_next, mask_bits;
  logic [HOST_BYTES-1:0] mask_q;
  int                    base;

  always_comb base = kind_q.wide ? (int'(idx) << LOG_DB) : int'(idx);

  // one lane per device byte; upper lanes only carry data on a wide device
  for (genvar k = 0; k < DEV_BYTES; k++) begin : g_lane
    always_comb begin
      dev_wdata[k*8 +: 8] = 8'h00;
      if (k == 0 || kind_q.wide)
        for (int b = 0; b < HOST_BYTES; b++)
          if (b == base + k) dev_wdata[k*8 +: 8] = wdata_q[b*8 +: 8];
    end
  end

  always_comb begin
    acc_next = acc_q;
    for (int b = 0; b < HOST_BYTES; b++) begin
      mask_bits[b*8 +: 8] = {8{mask_q[b]}};
      for (int k = 0; k < DEV_BYTES; k++)
        if (mask_q[b] && (k == 0 || kind_q.wide) && (b == base + k))
          acc_next[b*8 +: 8] = dev_rdata[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      acc_q   <= '0;
      mask_q  <= '0;
      kind_q  <= '0;
    end else if (load) begin
      wdata_q <= wdata_in;
      acc_q   <= '0;
      mask_q  <= mask_in;
      kind_q  <= kind_in;
    end else if (step && !kind_q.write) begin
      acc_q <= acc_next;
    end
  end

  assign rdata = acc_q;

  // R9
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q & ~mask_bits) == '0);

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nand_adapt_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int DEV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [1:0]        host_req_window,
  input  logic [1:0]        host_req_size,
  input  logic [HOST_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [HOST_W-1:0] host_rsp_rdata,
  input  logic [1:0]        cs_dev_type,
  input  logic [1:0]        cs_dev_size,
  output logic              busy,
  output logic              nand_valid,
  input  logic              nand_ready,
  output logic              nand_write,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DEV_W-1:0]  nand_wdata,
  input  logic [DEV_W-1:0]  nand_rdata
);

  localparam int HOST_BYTES = HOST_W / 8;
  localparam int DEV_BYTES  = DEV_W / 8;
  localparam int CNT_W      = $clog2(HOST_BYTES) + 1;

  acc_kind_t             kind_in, kind_q;
  logic [CNT_W-1:0]      ncycles, idx;
  logic [HOST_BYTES-1:0] mask;
  logic                  load, step;

  nand_adapt_plan #(.HOST_BYTES(HOST_BYTES), .DEV_BYTES(DEV_BYTES), .CNT_W(CNT_W)) u_plan (
    .win(host_req_window), .write(host_req_write), .size(host_req_size),
    .dev_type(cs_dev_type), .dev_size(cs_dev_size),
    .kind(kind_in), .ncycles(ncycles), .mask(mask)
  );

  nand_adapt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(host_req_valid), .req_write(host_req_write), .req_ncycles(ncycles),
    .req_ready(host_req_ready), .load(load), .busy(busy),
    .dev_valid(nand_valid), .dev_ready(nand_ready), .step(step), .idx(idx),
    .rsp_valid(host_rsp_valid), .rsp_ready(host_rsp_ready)
  );

  nand_adapt_datapath #(.HOST_BYTES(HOST_BYTES), .DEV_BYTES(DEV_BYTES), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .kind_in(kind_in), .mask_in(mask), .wdata_in(host_req_wdata), .idx(idx),
    .dev_rdata(nand_rdata), .dev_wdata(nand_wdata), .kind_q(kind_q),
    .rdata(host_rsp_rdata)
  );

  assign nand_write = kind_q.write;
  assign nand_cle   = nand_valid && kind_q.cle;
  assign nand_ale   = nand_valid && kind_q.ale;

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nand_cle, nand_ale}));

  // R10
  read_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_valid && !nand_write |-> !nand_cle && !nand_ale);

  // R7
  non_nand_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && (cs_dev_type != DEVTYPE_NAND) |=> !nand_valid);

  // R11
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_valid && !nand_ready |=> nand_valid && $stable(nand_wdata));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_rdata));

endmodule

// File: tb/test_nand_width_adapter.sv
module test_nand_width_adapter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [1:0]  host_req_window = 2'b00;
  logic [1:0]  host_req_size = 2'b00;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b1;
  logic [31:0] host_rsp_rdata;
  logic [1:0]  cs_dev_type = 2'b10;
  logic [1:0]  cs_dev_size = 2'b00;
  logic        busy;
  logic        nand_valid;
  logic        nand_ready = 1'b1;
  logic        nand_write;
  logic        nand_cle;
  logic        nand_ale;
  logic [15:0] nand_wdata;
  logic [15:0] nand_rdata;

  always #5 clk = ~clk;

  nand_width_adapter i_nand_width_adapter (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // device model: logs every completed cycle, serves a known word stream
  int          log_n = 0;
  int          rd_cnt = 0;
  logic [18:0] log_e [64];

  function automatic logic [15:0] rd_word(int k);
    logic [7:0] kk = k[7:0];
    return {8'hA0 + kk, 8'h10 + kk};
  endfunction

  assign nand_rdata = rd_word(rd_cnt);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && nand_valid && nand_ready) begin
      log_e[log_n[5:0]] <= {nand_cle, nand_ale, nand_write, nand_wdata};
      log_n <= log_n + 1;
      if (!nand_write) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // entry: {cle, ale, write, data}
  task automatic chk_cyc(string tag, int at, logic [18:0] exp);
    chk_eq(tag, 32'(log_e[at[5:0]]), 32'(exp));
  endtask

  task automatic access(input bit wr, input logic [1:0] win, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    while (!host_req_ready) @(negedge clk);
    host_req_valid  = 1'b1;
    host_req_write  = wr;
    host_req_window = win;
    host_req_size   = sz;
    host_req_wdata  = wd;
    @(negedge clk);
    host_req_valid = 1'b0;
    rd = '0;
    if (wr) begin
      while (!host_req_ready) @(negedge clk);
    end else begin
      while (!host_rsp_valid) @(negedge clk);
      rd = host_rsp_rdata;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk_eq("R8 reset ready", 32'(host_req_ready), 1);
    chk_eq("R8 reset busy", 32'(busy), 0);
    chk_eq("R8 reset nand_valid", 32'(nand_valid), 0);
    chk_eq("R11 reset rsp_valid", 32'(host_rsp_valid), 0);
  endtask

  task automatic t_narrow_writes();
    logic [31:0] r; int b;
    cs_dev_type = 2'b10; cs_dev_size = 2'b00;
    b = log_n;
    access(1, 2'b01, 2'b00, 32'hDEAD_BE5A, r);
    chk_eq("R1 R2 cmd byte count", 32'(log_n - b), 1);
    chk_cyc("R1 cmd byte cle", b, {3'b101, 16'h005A});
    b = log_n;
    access(1, 2'b10, 2'b10, 32'h1234_5678, r);
    chk_eq("R2 addr word count", 32'(log_n - b), 4);
    chk_cyc("R1 R2 addr byte0", b,     {3'b011, 16'h0078});
    chk_cyc("R2 addr byte1",    b + 1, {3'b011, 16'h0056});
    chk_cyc("R2 addr byte2",    b + 2, {3'b011, 16'h0034});
    chk_cyc("R2 addr byte3",    b + 3, {3'b011, 16'h0012});
    b = log_n;
    access(1, 2'b00, 2'b01, 32'hFFFF_C3B4, r);
    chk_eq("R2 data half count", 32'(log_n - b), 2);
    chk_cyc("R1 R2 data byte0", b,     {3'b001, 16'h00B4});
    chk_cyc("R2 data byte1",    b + 1, {3'b001, 16'h00C3});
  endtask

  task automatic t_narrow_reads();
    logic [31:0] r; int b, k;
    cs_dev_type = 2'b10; cs_dev_size = 2'b00;
    b = log_n; k = rd_cnt;
    access(0, 2'b00, 2'b10, '0, r);
    chk_eq("R3 word read count", 32'(log_n - b), 4);
    chk_eq("R3 word read data", r, {rd_word(k+3)[7:0], rd_word(k+2)[7:0],
                                    rd_word(k+1)[7:0], rd_word(k)[7:0]});
    chk_cyc("R1 R3 read cycle no strobe", b, {3'b000, 16'h0000});
    k = rd_cnt;
    access(0, 2'b11, 2'b01, '0, r);
    chk_eq("R3 R9 half read data", r, {16'h0, rd_word(k+1)[7:0], rd_word(k)[7:0]});
  endtask

  task automatic t_wide();
    logic [31:0] r; int b, k;
    cs_dev_type = 2'b10; cs_dev_size = 2'b01;
    b = log_n;
    access(1, 2'b00, 2'b10, 32'h1234_5678, r);
    chk_eq("R4 wide word write count", 32'(log_n - b), 2);
    chk_cyc("R4 wide low half", b,     {3'b001, 16'h5678});
    chk_cyc("R4 wide high half", b + 1, {3'b001, 16'h1234});
    b = log_n;
    access(1, 2'b01, 2'b01, 32'hAAAA_0F70, r);
    chk_eq("R4 wide half write count", 32'(log_n - b), 1);
    chk_cyc("R1 R4 wide cmd half", b, {3'b101, 16'h0F70});
    k = rd_cnt;
    access(0, 2'b00, 2'b10, '0, r);
    chk_eq("R4 wide word read", r, {rd_word(k+1), rd_word(k)});
    k = rd_cnt; b = log_n;
    access(0, 2'b00, 2'b01, '0, r);
    chk_eq("R4 R9 wide half read", r, {16'h0, rd_word(k)});
    chk_eq("R4 wide half read count", 32'(log_n - b), 1);
  endtask

  task automatic t_byte_on_wide();
    logic [31:0] r; int b, k;
    cs_dev_type = 2'b10; cs_dev_size = 2'b01;
    b = log_n;
    access(1, 2'b00, 2'b00, 32'hABCD_12EF, r);
    chk_eq("R5 byte write count", 32'(log_n - b), 1);
    chk_cyc("R5 byte write passes low half", b, {3'b001, 16'h12EF});
    k = rd_cnt; b = log_n;
    access(0, 2'b00, 2'b00, '0, r);
    chk_eq("R5 byte read count", 32'(log_n - b), 1);
    chk_eq("R5 R9 byte read zero-extended", r, {24'h0, rd_word(k)[7:0]});
  endtask

  task automatic t_size_upper_bit();
    logic [31:0] r; int b;
    cs_dev_type = 2'b10; cs_dev_size = 2'b10;
    b = log_n;
    access(1, 2'b00, 2'b10, 32'h0403_0201, r);
    chk_eq("R6 size 10 acts 8-bit", 32'(log_n - b), 4);
    chk_cyc("R6 size 10 last byte", b + 3, {3'b001, 16'h0004});
    cs_dev_size = 2'b11;
    b = log_n;
    access(1, 2'b00, 2'b10, 32'h0403_0201, r);
    chk_eq("R6 size 11 acts 16-bit", 32'(log_n - b), 2);
    chk_cyc("R6 size 11 first half", b, {3'b001, 16'h0201});
  endtask

  task automatic t_not_nand();
    logic [31:0] r; int b;
    cs_dev_size = 2'b01;
    cs_dev_type = 2'b00;
    b = log_n;
    access(1, 2'b01, 2'b10, 32'h1111_2222, r);
    chk_eq("R7 type 00 write dropped", 32'(log_n - b), 0);
    access(0, 2'b00, 2'b10, '0, r);
    chk_eq("R7 type 00 read zero", r, 0);
    cs_dev_type = 2'b11;
    access(0, 2'b00, 2'b01, '0, r);
    chk_eq("R7 type 11 read zero", r, 0);
    chk_eq("R7 no device cycles", 32'(log_n - b), 0);
  endtask

  task automatic t_ctrl_read();
    logic [31:0] r; int b;
    cs_dev_type = 2'b10; cs_dev_size = 2'b00;
    b = log_n;
    access(0, 2'b01, 2'b10, '0, r);
    chk_eq("R10 cmd window read zero", r, 0);
    access(0, 2'b10, 2'b01, '0, r);
    chk_eq("R10 addr window read zero", r, 0);
    chk_eq("R10 no device cycles", 32'(log_n - b), 0);
  endtask

  task automatic t_stall();
    int b;
    cs_dev_type = 2'b10; cs_dev_size = 2'b01;
    b = log_n;
    @(negedge clk);
    while (!host_req_ready) @(negedge clk);
    nand_ready      = 1'b0;
    host_req_valid  = 1'b1;
    host_req_write  = 1'b1;
    host_req_window = 2'b00;
    host_req_size   = 2'b11;
    host_req_wdata  = 32'h9ABC_DEF0;
    @(negedge clk);
    host_req_valid = 1'b0;
    chk_eq("R8 busy after accept", 32'(busy), 1);
    chk_eq("R8 not ready while busy", 32'(host_req_ready), 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk_eq("R11 valid held in stall", 32'(nand_valid), 1);
    chk_eq("R11 wdata held in stall", 32'(nand_wdata), 32'h0000_DEF0);
    chk_eq("R11 no cycle in stall", 32'(log_n - b), 0);
    nand_ready = 1'b1;
    while (!host_req_ready) @(negedge clk);
    chk_eq("R8 busy low after last", 32'(busy), 0);
    chk_eq("R11 size 11 as word count", 32'(log_n - b), 2);
    chk_cyc("R11 size 11 high half", b + 1, {3'b001, 16'h9ABC});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_writes();
    t_narrow_reads();
    t_wide();
    t_byte_on_wide();
    t_size_upper_bit();
    t_not_nand();
    t_ctrl_read();
    t_stall();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule